// File: doc/BRIEF.md
# Comma-Aligning Serial Deserializer

This block takes a serial bit stream, one bit per cycle of its recovered bit clock, and assembles it into 10-bit parallel words. A 7-bit window slides over the most recent serial history on every bit clock and looks for either polarity of the comma pattern. Each word that holds the final bit of a comma is presented with a flag raised for that word's whole period.

When alignment is enabled, a detected comma moves the word boundary so that the comma fills bits 0 to 6 of the next presented word. When alignment is disabled, the current boundary is kept whatever the data holds. A byte clock and its complement come from a divide-by-ten bit counter. The next stage captures each word on the rising edge of the byte clock.

A loopback select picks the bit source. The source is either the external serial input or the internally looped transmit stream. The input that is not selected has no effect.

Top module: `comma_align_deser`

## Requirements
- R1: While rst_ni is low, word_o is 0, comma_o is 0, bclk_o is 0 and bclk_n_o is 1.
- R2: The bit received first in a word appears at word_o[0] and the last at word_o[9]. With no realignment, a new word is presented every 10 bit clocks.
- R3: Both comma polarities are detected at any bit position, not only on a word boundary. The positive comma is the transmission-order sequence 0,0,1,1,1,1,1 and the negative comma is 1,1,0,0,0,0,0. comma_o is 1 for exactly the one word period of the word that holds the comma's last bit, and it is 0 for every other word.
- R4: While align_en_i is 1, a detected comma restarts the word boundary so that the next presented word carries the comma in word_o[6:0]. With a word of 0,0,1,1,1,1,1,0,1,0 in transmission order, word_o is 10'b0101111100.
- R5: While align_en_i is 0, a comma does not move the word boundary.
- R6: bclk_o is high for the first 5 bit clocks of a word period and low for the last 5. It rises one bit clock after word_o takes a new word, and word_o does not change on that rising edge. A realignment may make one period irregular. bclk_n_o is always the inverse of bclk_o.
- R7: When lpbk_i is 1, the bit source is loop_ser_i and ser_i has no effect. When lpbk_i is 0, the bit source is ser_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | External serial data |
| loop_ser_i | input | 1 | Internally looped transmit serial data |
| lpbk_i | input | 1 | 1 selects loop_ser_i as the bit source |
| align_en_i | input | 1 | 1 lets a detected comma realign the word boundary |
| word_o | output | 10 | Parallel word; bit 0 was received first |
| comma_o | output | 1 | Word holds the last bit of a comma |
| bclk_o | output | 1 | Byte clock |
| bclk_n_o | output | 1 | Inverted byte clock |

## Verification
Random data with alignment off exercises bit ordering and the free-running boundary. Random data also produces incidental comma matches, which shows whether the flag follows the sliding window or only the boundary. An alternating comma-character stream sent at a deliberate offset shows the difference between the two alignment settings. With alignment off the aligned word must never appear; with alignment on it must appear once the first comma passes. The loopback phases drive garbage on the unselected input while commas travel on the selected one. A stream with negative commas only confirms the second polarity is matched on its own.

// File: rtl/cad_pkg.sv
package cad_pkg;
  localparam int unsigned DEF_WORD_W  = 10;
  localparam int unsigned DEF_COMMA_W = 7;
  localparam logic [DEF_COMMA_W-1:0] DEF_COMMA_PAT = 7'b0011111; // oldest bit at MSB
  localparam int unsigned N_POL = 2;
endpackage

// File: rtl/cad_src_sel.sv
module cad_src_sel (
  input  logic ext_i,
  input  logic loop_i,
  input  logic lpbk_i,
  output logic bit_o
);
  assign bit_o = lpbk_i ? loop_i : ext_i;
endmodule

// File: rtl/cad_window.sv
module cad_window #(
  parameter int unsigned WORD_W  = 10,
  parameter int unsigned COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b0011111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  output logic [WORD_W-1:0] hist_o,
  output logic              det_o
);
  localparam int unsigned N_POL = cad_pkg::N_POL;

  logic [WORD_W-1:0] sr_q;
  logic [N_POL-1:0]  match;

  // sr_q[0] newest bit, sr_q[WORD_W-1] oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[WORD_W-2:0], bit_i};
  end

  for (genvar p = 0; p < N_POL; p++) begin : g_pol
    localparam logic [COMMA_W-1:0] PAT = (p == 0) ? COMMA_PAT : ~COMMA_PAT;
    assign match[p] = (sr_q[COMMA_W-1:0] == PAT);
  end

  assign det_o  = |match;
  assign hist_o = sr_q;
endmodule

// File: rtl/cad_framer.sv
module cad_framer #(
  parameter int unsigned WORD_W  = 10,
  parameter int unsigned COMMA_W = 7,
  localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_i,
  input  logic             align_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             bclk_o,
  output logic             bclk_n_o
);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(WORD_W - 2);
  localparam logic [CNT_W-1:0] ALN_CNT = CNT_W'(COMMA_W - 1);
  localparam logic [CNT_W-1:0] HI_LIM  = CNT_W'(WORD_W / 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_n_q;

  // cnt = word index of the newest bit in the history window
  always_comb begin
    if (align_en_i && det_i)  cnt_d = ALN_CNT;
    else if (cnt_q == LAST)   cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= RST_CNT;
      bclk_q   <= 1'b0;
      bclk_n_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      bclk_q   <= (cnt_d < HI_LIM);
      bclk_n_q <= !(cnt_d < HI_LIM);
    end
  end

  assign load_o   = (cnt_d == LAST);
  assign cnt_o    = cnt_q;
  assign bclk_o   = bclk_q;
  assign bclk_n_o = bclk_n_q;
endmodule

// File: rtl/cad_word_out.sv
module cad_word_out #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              det_i,
  input  logic [WORD_W-1:0] hist_i,
  output logic [WORD_W-1:0] word_o,
  output logic              comma_o
);
  logic [WORD_W-1:0] word_d, word_q;
  logic              pend_q, comma_q;

  // oldest history bit lands on word bit 0
  for (genvar k = 0; k < WORD_W; k++) begin : g_rev
    assign word_d[k] = hist_i[WORD_W-1-k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      comma_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (load_i) begin
      word_q  <= word_d;
      comma_q <= pend_q | det_i;
      pend_q  <= 1'b0;
    end else begin
      pend_q  <= pend_q | det_i;
    end
  end

  assign word_o  = word_q;
  assign comma_o = comma_q;
endmodule

// File: rtl/comma_align_deser.sv
module comma_align_deser #(
  parameter int unsigned WORD_W  = cad_pkg::DEF_WORD_W,
  parameter int unsigned COMMA_W = cad_pkg::DEF_COMMA_W,
  parameter logic [COMMA_W-1:0] COMMA_PAT = cad_pkg::DEF_COMMA_PAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              loop_ser_i,
  input  logic              lpbk_i,
  input  logic              align_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              comma_o,
  output logic              bclk_o,
  output logic              bclk_n_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic              bit_w;
  logic [WORD_W-1:0] hist_w;
  logic              det_w;
  logic              load_w;
  logic [CNT_W-1:0]  cnt_w;

  cad_src_sel u_src (
    .ext_i  (ser_i),
    .loop_i (loop_ser_i),
    .lpbk_i (lpbk_i),
    .bit_o  (bit_w)
  );

  cad_window #(.WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (bit_w),
    .hist_o (hist_w),
    .det_o  (det_w)
  );

  cad_framer #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_frm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_i      (det_w),
    .align_en_i (align_en_i),
    .cnt_o      (cnt_w),
    .load_o     (load_w),
    .bclk_o     (bclk_o),
    .bclk_n_o   (bclk_n_o)
  );

  cad_word_out #(.WORD_W(WORD_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_w),
    .det_i   (det_w),
    .hist_i  (hist_w),
    .word_o  (word_o),
    .comma_o (comma_o)
  );
endmodule

// File: rtl/cad_checker.sv
module cad_checker #(
  parameter int unsigned WORD_W  = 10,
  parameter int unsigned COMMA_W = 7,
  parameter int unsigned CNT_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              align_en_i,
  input logic [WORD_W-1:0] word_o,
  input logic              comma_o,
  input logic              bclk_o,
  input logic              bclk_n_o,
  input logic              det_w,
  input logic [CNT_W-1:0]  cnt_w
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ALN  = CNT_W'(COMMA_W - 1);

  AST_CLK_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_n_o == !bclk_o); // R6

  AST_WORD_STABLE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |-> $stable(word_o) && $stable(comma_o)); // R6

  AST_ALIGN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_en_i && det_w |=> cnt_w == ALN); // R4

  AST_FREE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(align_en_i && det_w) && cnt_w != LAST |=> cnt_w == $past(cnt_w) + 1'b1); // R5

  AST_FREE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(align_en_i && det_w) && cnt_w == LAST |=> cnt_w == '0); // R2

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w != LAST |-> $stable(comma_o) && $stable(word_o)); // R3

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w <= LAST); // R2
endmodule

bind comma_align_deser cad_checker #(
  .WORD_W(WORD_W), .COMMA_W(COMMA_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .align_en_i (align_en_i),
  .word_o     (word_o),
  .comma_o    (comma_o),
  .bclk_o     (bclk_o),
  .bclk_n_o   (bclk_n_o),
  .det_w      (det_w),
  .cnt_w      (cnt_w)
);

// File: tb/sim_comma_align_deser.sv
`timescale 1ns/1ps
module sim_comma_align_deser;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser = 1'b0, loop_ser = 1'b0, lpbk = 1'b0, align_en = 1'b0;
  logic [9:0] word;
  logic       comma, bclk, bclk_n;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  comma_align_deser u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(ser), .loop_ser_i(loop_ser),
    .lpbk_i(lpbk), .align_en_i(align_en),
    .word_o(word), .comma_o(comma), .bclk_o(bclk), .bclk_n_o(bclk_n)
  );

  // reference model state
  bit   hist[$];
  int   m_phase = 8;
  bit   m_pend = 0, m_comma = 0, m_bclk = 0;
  logic [9:0] m_word = '0;
  int   hit_aligned = 0, hit_flag = 0;

  localparam bit K_NEG [10] = '{0,0,1,1,1,1,1,0,1,0};
  localparam bit K_POS [10] = '{1,1,0,0,0,0,0,1,0,1};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit win_det();
    int s = hist.size();
    bit p = 1, n = 1;
    for (int k = 0; k < 7; k++) begin
      bit b = hist[s-7+k];
      if (b != ((k < 2) ? 1'b0 : 1'b1)) p = 0;
      if (b != ((k < 2) ? 1'b1 : 1'b0)) n = 0;
    end
    return p | n;
  endfunction

  task automatic model_step();
    bit d = win_det();
    if (align_en && d) m_phase = 6;
    else m_phase = (m_phase == 9) ? 0 : m_phase + 1;
    if (m_phase == 9) begin
      int s = hist.size();
      for (int k = 0; k < 10; k++) m_word[k] = hist[s-10+k];
      m_comma = m_pend | d;
      m_pend = 0;
    end else m_pend = m_pend | d;
    m_bclk = (m_phase < 5);
    hist.push_back(lpbk ? loop_ser : ser);
    if (hist.size() > 16) void'(hist.pop_front());
  endtask

  task automatic compare();
    check(word === m_word, "R2 word", 32'(word), 32'(m_word));
    check(comma === m_comma, "R3 comma flag", 32'(comma), 32'(m_comma));
    check(bclk === m_bclk, "R6 byte clock", 32'(bclk), 32'(m_bclk));
    check(bclk_n === !m_bclk, "R6 inverted byte clock", 32'(bclk_n), 32'(!m_bclk));
    if (comma && (word == 10'b0101111100 || word == 10'b1010000011)) hit_aligned++;
    if (comma) hit_flag++;
  endtask

  task automatic tick(input bit s, input bit l);
    @(negedge clk);
    compare();
    ser = s; loop_ser = l;
    model_step();
  endtask

  task automatic send_k(input bit on_loop, input bit pos);
    for (int k = 0; k < 10; k++) begin
      bit b = pos ? K_POS[k] : K_NEG[k];
      if (on_loop) tick(1'($urandom), b);
      else         tick(b, 1'($urandom));
    end
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int k = 0; k < 10; k++) hist.push_back(1'b0);
    repeat (3) @(negedge clk);
    check(word === 10'd0, "R1 reset word", 32'(word), 0);
    check(comma === 1'b0, "R1 reset comma", 32'(comma), 0);
    check(bclk === 1'b0, "R1 reset bclk", 32'(bclk), 0);
    check(bclk_n === 1'b1, "R1 reset bclk_n", 32'(bclk_n), 1);
    rst_ni = 1'b1;
    model_step();

    // R2 R5: random data, alignment off
    repeat (400) tick(1'($urandom), 1'($urandom));

    // R5: misaligned comma stream must not become aligned
    while (m_phase != 4) tick(1'($urandom), 1'b0);
    hit_aligned = 0;
    for (int i = 0; i < 20; i++) send_k(0, i[0]);
    check(hit_aligned == 0, "R5 no realign with align off", 32'(hit_aligned), 0);

    // R4: same stream with alignment on
    align_en = 1'b1;
    hit_aligned = 0;
    for (int i = 0; i < 20; i++) send_k(0, i[0]);
    check(hit_aligned > 0, "R4 aligned comma word", 32'(hit_aligned), 1);

    // R3 R4: random with sprinkled commas at random offsets
    for (int i = 0; i < 30; i++) begin
      repeat ($urandom_range(3, 17)) tick(1'($urandom), 1'($urandom));
      send_k(0, 1'($urandom));
    end

    // R7: loopback, garbage on ser_i
    lpbk = 1'b1;
    hit_aligned = 0;
    for (int i = 0; i < 20; i++) begin
      repeat ($urandom_range(0, 9)) tick(1'($urandom), 1'($urandom));
      send_k(1, i[0]);
      send_k(1, !i[0]);
    end
    check(hit_aligned > 0, "R7 commas taken from loop input", 32'(hit_aligned), 1);

    // R3: negative comma only, alignment toggling
    hit_flag = 0;
    for (int i = 0; i < 20; i++) begin
      align_en = i[1];
      repeat ($urandom_range(2, 11)) tick(1'($urandom), 1'b0);
      send_k(1, 1);
    end
    check(hit_flag > 0, "R3 negative comma flagged", 32'(hit_flag), 1);

    // R7: back to external input
    lpbk = 1'b0;
    align_en = 1'b1;
    repeat (200) tick(1'($urandom), 1'($urandom));
    for (int i = 0; i < 10; i++) send_k(0, i[0]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) cyc <= cyc + 1;
endmodule